// File: doc/BRIEF.md
# Four-Channel Bus-Master DMA Control Registers

This block holds the software-visible control state for a storage controller with four bus-master channels. Each channel has three 32-bit registers: a command register, a descriptor-table base pointer and a second control register. Software reaches them through a plain register port with a write strobe, a read strobe and a word address. The block turns these registers into per-channel DMA enable, direction, base pointer and large-transfer mode signals for the DMA engine. When software stops a channel whose engine is still busy, the block raises a one-cycle abort pulse.

The block also filters device interrupts. A steering bit that exists only in channel 2's command register either passes the interrupts of all four channels or passes only the interrupt of the channel named by a shadow device-select input. For each channel it reports which PIO or task-file access attempts must be refused with a target-abort because bus-master mode is enabled. Channels are paired (0 with 1, 2 with 3): the even channel's second control register shows a read-only copy of its odd partner's command byte.

The register port has no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. Read data is valid in the same cycle as `reg_rd`.

Top module: `busmaster_regfile`

## Requirements
- R1: After reset every register reads zero, and `dma_en`, `dma_dir`, `big_xfer`, `dma_abort`, `pio_tabort` and `desc_base` are all zero.
- R2: `reg_addr` is a word address. Bits [3:2] select the channel and bits [1:0] select the register: 0 = command, 1 = descriptor base, 2 = second control, 3 = unmapped (reads zero, writes ignored). `reg_rdata` is combinational, valid in the same cycle as `reg_rd`, and zero while `reg_rd` is low.
- R3: In the command register, bit 0 drives `dma_en` and bit 3 drives `dma_dir` (1 = device to memory, 0 = memory to device). Bit 2 and bits 31:4 are ignored on write and read zero.
- R4: Command bit 1 (interrupt steering) is writable only in channel 2. In channels 0, 1 and 3 it is ignored on write and reads zero.
- R5: `irq_out[c]` equals `dev_irq[c]` when the steering bit is 1. When the steering bit is 0, `irq_out[c]` equals `dev_irq[c]` only for c equal to `shadow_sel`, and is zero for every other channel.
- R6: In the descriptor base register, bits 31:2 are writable and appear on that channel's 32-bit slice of `desc_base`. Bits 1:0 read zero.
- R7: In the second control register, bit 0 is writable and drives `big_xfer`. Bit 23 (simplex-only status) always reads zero. All other bits below 24 read zero.
- R8: Bits 31:24 of channel 0's second control register read channel 1's command bits 7:0, and the same bits of channel 2's register read channel 3's command bits 7:0. In channels 1 and 3 this field reads zero. Writes to it are ignored.
- R9: A command write that clears bit 0 of a channel while its `dma_en` is 1 and its `dma_busy` is 1 makes `dma_abort` for that channel high for exactly the one cycle after the write edge. In that same cycle `dma_en` is already 0.
- R10: No abort pulse is produced when the channel's `dma_busy` is low at the clearing write, or when the write leaves bit 0 set.
- R11: `pio_tabort[c]` is high exactly when `pio_access[c]` is high and `dma_en[c]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address: channel in [3:2], register in [1:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| dma_busy | input | 4 | Per-channel DMA engine busy |
| dma_en | output | 4 | Per-channel bus-master enable |
| dma_dir | output | 4 | Per-channel direction, 1 = device to memory |
| big_xfer | output | 4 | Per-channel large-transfer mode |
| desc_base | output | 128 | Descriptor base pointers, channel c at [32c+31:32c] |
| dma_abort | output | 4 | One-cycle abort pulse per channel |
| dev_irq | input | 4 | Raw device interrupts |
| shadow_sel | input | 2 | Shadow device-select channel number |
| irq_out | output | 4 | Gated interrupts |
| pio_access | input | 4 | PIO or task-file access attempt per channel |
| pio_tabort | output | 4 | Target-abort request per channel |

## Verification
On every cycle the assertions check that each abort pulse lasts a single cycle, falls on a disabled channel and follows a busy cycle. They also check that gated interrupts never appear without their raw source, that target-abort follows enable and access, and that reserved, simplex and odd-channel mirror bits read zero. Only the bench scenarios can show the exact bit values after each write: the direction and enable encodings, the channel-2-only steering bit, the contents of the partner mirror, and the full table of interrupt selections across steering and shadow-select values.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_BASE = 2'd1,
    REG_CTL2 = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CMD_EN_BIT    = 0;
  localparam int CMD_STEER_BIT = 1;
  localparam int CMD_DIR_BIT   = 3;
  localparam int CTL2_BIG_BIT  = 0;
  localparam int MIRROR_LSB    = 24;
  localparam int DATA_W        = 32;
endpackage

// File: rtl/bmr_chan.sv
module bmr_chan #(
  parameter bit HAS_STEER = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cmd,
  input  logic        wr_base,
  input  logic        wr_ctl2,
  input  logic [31:0] wdata,
  input  logic        busy,
  output logic        en,
  output logic        dir,
  output logic        steer,
  output logic        big,
  output logic        abort,
  output logic [29:0] base,
  output logic [7:0]  cmd_byte
);
  import bmr_pkg::*;

  logic stop_req;
  assign stop_req = wr_cmd && en && !wdata[CMD_EN_BIT] && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      dir   <= 1'b0;
      steer <= 1'b0;
      big   <= 1'b0;
      abort <= 1'b0;
      base  <= '0;
    end else begin
      abort <= stop_req;
      if (wr_cmd) begin
        en    <= wdata[CMD_EN_BIT];
        dir   <= wdata[CMD_DIR_BIT];
        steer <= HAS_STEER ? wdata[CMD_STEER_BIT] : 1'b0;
      end
      if (wr_base) base <= wdata[31:2];
      if (wr_ctl2) big  <= wdata[CTL2_BIG_BIT];
    end
  end

  assign cmd_byte = {4'b0000, dir, 1'b0, steer, en};
endmodule

// File: rtl/bmr_irq_gate.sv
module bmr_irq_gate #(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 2
) (
  input  logic [NUM_CH-1:0] dev_irq,
  input  logic [SEL_W-1:0]  sel,
  input  logic              steer_all,
  output logic [NUM_CH-1:0] irq_out
);
  logic [NUM_CH-1:0] sel_mask;

  always_comb begin
    sel_mask = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (SEL_W'(c) == sel) sel_mask[c] = 1'b1;
    end
  end

  assign irq_out = steer_all ? dev_irq : (dev_irq & sel_mask);
endmodule

// File: rtl/busmaster_regfile.sv
module busmaster_regfile #(
  parameter int NUM_CH   = 4,
  parameter int STEER_CH = 2,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W  = CH_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_CH-1:0]    dma_busy,
  output logic [NUM_CH-1:0]    dma_en,
  output logic [NUM_CH-1:0]    dma_dir,
  output logic [NUM_CH-1:0]    big_xfer,
  output logic [NUM_CH*32-1:0] desc_base,
  output logic [NUM_CH-1:0]    dma_abort,
  input  logic [NUM_CH-1:0]    dev_irq,
  input  logic [CH_W-1:0]      shadow_sel,
  output logic [NUM_CH-1:0]    irq_out,
  input  logic [NUM_CH-1:0]    pio_access,
  output logic [NUM_CH-1:0]    pio_tabort
);
  import bmr_pkg::*;

  reg_sel_e          rsel;
  logic [CH_W-1:0]   ch;
  logic [NUM_CH-1:0] steer_v;
  logic [7:0]        cmd_byte [NUM_CH];
  logic [29:0]       base_v   [NUM_CH];
  logic [31:0]       cmd_rd   [NUM_CH];
  logic [31:0]       base_rd  [NUM_CH];
  logic [31:0]       ctl2_rd  [NUM_CH];

  assign rsel = reg_sel_e'(reg_addr[1:0]);
  assign ch   = reg_addr[ADDR_W-1:2];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    logic [7:0] mirror;
    assign hit = reg_wr && (ch == CH_W'(c));

    bmr_chan #(.HAS_STEER(c == STEER_CH)) i_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cmd   (hit && rsel == REG_CMD),
      .wr_base  (hit && rsel == REG_BASE),
      .wr_ctl2  (hit && rsel == REG_CTL2),
      .wdata    (reg_wdata),
      .busy     (dma_busy[c]),
      .en       (dma_en[c]),
      .dir      (dma_dir[c]),
      .steer    (steer_v[c]),
      .big      (big_xfer[c]),
      .abort    (dma_abort[c]),
      .base     (base_v[c]),
      .cmd_byte (cmd_byte[c])
    );

    if ((c % 2 == 0) && (c + 1 < NUM_CH)) begin : g_mirror
      assign mirror = cmd_byte[c+1];
    end else begin : g_no_mirror
      assign mirror = 8'h00;
    end

    assign desc_base[c*32 +: 32] = {base_v[c], 2'b00};
    assign cmd_rd[c]  = {24'h0, cmd_byte[c]};
    assign base_rd[c] = {base_v[c], 2'b00};
    // bit 23 (simplex-only) stays zero: every channel may master at any time
    assign ctl2_rd[c] = {mirror, 23'h0, big_xfer[c]};
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd && (int'(ch) < NUM_CH)) begin
      case (rsel)
        REG_CMD:  reg_rdata = cmd_rd[ch];
        REG_BASE: reg_rdata = base_rd[ch];
        REG_CTL2: reg_rdata = ctl2_rd[ch];
        default:  reg_rdata = '0;
      endcase
    end
  end

  bmr_irq_gate #(.NUM_CH(NUM_CH), .SEL_W(CH_W)) i_irq (
    .dev_irq   (dev_irq),
    .sel       (shadow_sel),
    .steer_all (steer_v[STEER_CH]),
    .irq_out   (irq_out)
  );

  assign pio_tabort = pio_access & dma_en;
endmodule

// File: rtl/bmr_chk.sv
module bmr_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic [NUM_CH-1:0] dma_en,
  input logic [NUM_CH-1:0] dma_abort,
  input logic [NUM_CH-1:0] dma_busy,
  input logic [NUM_CH-1:0] dev_irq,
  input logic [NUM_CH-1:0] irq_out,
  input logic [NUM_CH-1:0] pio_access,
  input logic [NUM_CH-1:0] pio_tabort
);
  // R3
  cmd_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[1:0] == 2'd0) |-> (reg_rdata[2] == 1'b0 && reg_rdata[31:4] == '0));
  // R6
  base_lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[1:0] == 2'd1) |-> (reg_rdata[1:0] == 2'b00));
  // R7
  simplex_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[1:0] == 2'd2) |-> (reg_rdata[23:1] == '0));
  // R8
  odd_mirror_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[1:0] == 2'd2 && reg_addr[2]) |-> (reg_rdata[31:24] == 8'h00));
  // R5
  irq_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_out & ~dev_irq) == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R9
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_abort[c] |=> !dma_abort[c]);
    // R9
    abort_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_abort[c] |-> !dma_en[c]);
    // R10
    abort_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_abort[c] |-> $past(dma_busy[c]));
    // R11
    tabort_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pio_access[c] && dma_en[c]) |-> pio_tabort[c]);
    // R11
    tabort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_en[c] || !pio_access[c]) |-> !pio_tabort[c]);
  end
endmodule

bind busmaster_regfile bmr_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_bmr_chk (.*);

// File: tb/test_busmaster_regfile.sv
module test_busmaster_regfile;
  localparam int NCH = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [3:0]   dma_busy = '0, dma_en, dma_dir, big_xfer, dma_abort;
  logic [127:0] desc_base;
  logic [3:0]   dev_irq = '0, irq_out, pio_access = '0, pio_tabort;
  logic [1:0]   shadow_sel = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  busmaster_regfile i_busmaster_regfile (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int c, input int r, input logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'((c << 2) | r);
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int c, input int r, output logic [31:0] d);
    reg_addr = 4'((c << 2) | r);
    reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
    #1;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 3; r++) begin
        rd(c, r, d);
        chk(d == 0, "R1 reg after reset", d, 0);
      end
    chk({dma_en, dma_dir, big_xfer, dma_abort, pio_tabort} == 0 && desc_base == 0,
        "R1 outputs after reset", {dma_en, dma_dir, big_xfer, dma_abort}, 0);

    // R3 R4: command sweep
    for (int c = 0; c < NCH; c++)
      for (int v = 0; v < 16; v++) begin
        wr(c, 0, 32'hFFFF_FFF0 | 32'(v));
        rd(c, 0, d);
        e = 32'(v) & ((c == 2) ? 32'hB : 32'h9);
        chk(d == e, (c == 2) ? "R4 steer channel cmd readback" : "R3 R4 cmd readback", d, e);
        chk(dma_en[c] == v[0] && dma_dir[c] == v[3], "R3 enable/direction outputs",
            {dma_en[c], dma_dir[c]}, {v[0], v[3]});
        chk(dma_abort == 0, "R10 no abort when idle", dma_abort, 0);
      end
    for (int c = 0; c < NCH; c++) wr(c, 0, 0);

    // R2: read strobe low and unmapped register
    reg_addr = 4'h2;
    #1 chk(reg_rdata == 0, "R2 rdata without strobe", reg_rdata, 0);
    for (int c = 0; c < NCH; c++) begin
      wr(c, 3, 32'hFFFF_FFFF);
      rd(c, 3, d);
      chk(d == 0, "R2 unmapped reads zero", d, 0);
    end

    // R6: descriptor base
    for (int c = 0; c < NCH; c++)
      for (int p = 0; p < 4; p++) begin
        e = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'hA5A5_5A5B :
            (p == 2) ? 32'h0000_0003 : (32'h1357_9BDF + 32'(c));
        wr(c, 1, e);
        rd(c, 1, d);
        chk(d == (e & ~32'h3), "R6 base readback", d, e & ~32'h3);
        chk(desc_base[c*32 +: 32] == (e & ~32'h3), "R6 base output", desc_base[c*32 +: 32], e & ~32'h3);
      end

    // R7 R8: second control and partner mirror
    for (int c = 0; c < NCH; c++) begin
      wr(c, 2, 32'hFFFF_FFFF);
      chk(big_xfer[c] == 1'b1, "R7 big transfer set", big_xfer[c], 1);
      wr(c, 2, 32'hFFFF_FFFE);
      chk(big_xfer[c] == 1'b0, "R7 big transfer clear", big_xfer[c], 0);
    end
    wr(0, 2, 1);
    for (int v = 0; v < 16; v++) begin
      wr(1, 0, 32'(v));
      wr(3, 0, 32'(v ^ 15));
      rd(0, 2, d);
      e = ((32'(v) & 32'h9) << 24) | 32'h1;
      chk(d == e, "R8 channel 0 mirror", d, e);
      rd(2, 2, d);
      e = (32'(v ^ 15) & 32'h9) << 24;
      chk(d == e, "R8 channel 2 mirror", d, e);
      rd(1, 2, d);
      chk(d[31:1] == 0, "R8 odd channel field zero", d, 0);
    end
    wr(1, 0, 0);
    wr(3, 0, 0);
    wr(0, 2, 0);

    // R9 R10: abort behaviour
    for (int c = 0; c < NCH; c++) begin
      wr(c, 0, 1);
      dma_busy = 4'(1 << c);
      wr(c, 0, 0);
      chk(dma_abort == 4'(1 << c) && !dma_en[c], "R9 abort pulse", dma_abort, 4'(1 << c));
      @(negedge clk);
      chk(dma_abort == 0, "R9 abort one cycle", dma_abort, 0);
      wr(c, 0, 1);
      wr(c, 0, 9);
      chk(dma_abort == 0, "R10 no abort while enable stays", dma_abort, 0);
      dma_busy = 0;
      wr(c, 0, 0);
      chk(dma_abort == 0 && !dma_en[c], "R10 no abort when not busy", dma_abort, 0);
    end

    // R11: target-abort
    for (int c = 0; c < NCH; c++)
      for (int en = 0; en < 2; en++) begin
        wr(c, 0, 32'(en));
        for (int a = 0; a < 16; a++) begin
          pio_access = 4'(a);
          #1 e = 32'(a & (en << c));
          chk(pio_tabort == e[3:0], "R11 target-abort", pio_tabort, e[3:0]);
        end
        pio_access = 0;
        wr(c, 0, 0);
      end

    // R5: interrupt steering
    for (int s = 0; s < 2; s++) begin
      wr(2, 0, 32'(s << 1));
      for (int sel = 0; sel < 4; sel++)
        for (int v = 0; v < 16; v++) begin
          shadow_sel = 2'(sel);
          dev_irq = 4'(v);
          #1 e = (s == 1) ? 32'(v) : (32'(v) & (32'h1 << sel));
          chk(irq_out == e[3:0], "R5 interrupt gating", irq_out, e[3:0]);
        end
    end
    wr(2, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule